// File: doc/BRIEF.md
# Double-Buffered DMA Channel

A single DMA channel that copies bytes from a source address to a destination address, one byte for each request raised by an attached peripheral. Software prepares a block by loading the current source, destination and byte count, then arms the channel through a control register. While that block is running, software may place the source, destination and count of the following block in a set of shadow reload registers. At the end of a block the channel either takes over the shadow set and carries on with no software action, or halts and reports an overrun.

The end of a block is decided either by the channel, when its byte count runs out, or by the peripheral, which marks its final request. A second mode bit turns double buffering off, so that every block end halts the channel. Status bits record terminal count, overrun, a pending reload set and channel activity. A level interrupt reflects the enabled status bits. Memory is reached through a one-byte read/write master port with single-cycle read latency.

Top module: `dbuf_dma_chan`

## Requirements
- R1: After reset all eight registers read as zero and irq, dack, mem_rd and mem_wr are low.
- R2: Each accepted request produces a memory read of the current source address, in the next cycle a write of the returned byte to the current destination address, and in the cycle after that a one-cycle dack.
- R3: After every byte the current source and destination addresses (offsets 2 and 3) each grow by one and the current count (offset 4) shrinks by one.
- R4: With control bit 1 (peripheral flow) clear, a block ends on the byte that brings the current count to zero, and status bit 0 (terminal count) is set.
- R5: With control bit 1 set, a block ends on the byte whose request had dreq_last high; in double-buffer mode (control bit 2 set) terminal count is then left unchanged.
- R6: A write to the reload count (offset 7) sets status bit 2 (valid); writes to the reload addresses (offsets 5, 6) do not; writing 1 to status bits 0, 1 or 2 at offset 1 clears those bits.
- R7: In double-buffer mode, a block end with valid set copies offsets 5, 6, 7 into offsets 2, 3, 4, clears valid, keeps status bit 3 (active) set and continues with the next request.
- R8: In double-buffer mode, a block end with valid clear stops the channel, sets status bit 1 (overrun), clears active and clears the enable bit (control bit 0).
- R9: With control bit 2 clear, every block end stops the channel, sets both terminal count and overrun, clears active and clears enable.
- R10: irq is high exactly while (terminal count and control bit 3) or (overrun and control bit 4) holds.
- R11: While enable is clear a held request causes no memory access; a new request is only taken after the dack of the previous one.
- R12: Writes to offsets 2, 3 and 4 are ignored while active is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Register write strobe |
| sw_addr | input | 3 | Register offset for read and write |
| sw_wdata | input | W | Register write data |
| sw_rdata | output | W | Register read data for sw_addr (combinational) |
| dreq | input | 1 | Peripheral transfer request, held until dack |
| dreq_last | input | 1 | Marks the final request of a block (peripheral flow) |
| dack | output | 1 | One-cycle acknowledge after each byte write |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | W | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid the cycle after mem_rd |
| irq | output | 1 | Level interrupt |

## Verification
A wrong current address appears on mem_addr in the read or write cycle of the very next byte, and a wrong count or reload decision shows up at the block end as an early or late halt, a missing reload address, or a status read and irq level that disagree within the same cycle. Because the reference model predicts mem_rd, mem_wr, mem_addr, mem_wdata, dack and irq on every clock, most faults are caught within four cycles of the byte where the state first diverges. Register reads after each scenario then pin down the final counters, the status bits and the cleared enable.

// File: rtl/dbuf_dma_pkg.sv
`timescale 1ns/1ps
package dbuf_dma_pkg;

    // Register offsets; the order is part of the software contract.
    typedef enum logic [2:0] {
        RA_CTRL = 3'd0,
        RA_STAT = 3'd1,
        RA_CSRC = 3'd2,
        RA_CDST = 3'd3,
        RA_CCNT = 3'd4,
        RA_RSRC = 3'd5,
        RA_RDST = 3'd6,
        RA_RCNT = 3'd7
    } reg_addr_e;

    // Control register, bit 0 is the last member.
    typedef struct packed {
        logic ovr_ie;
        logic tc_ie;
        logic autoload;
        logic pflow;
        logic en;
    } ctrl_t;

    // Status register, bit 0 is the last member.
    typedef struct packed {
        logic active;
        logic valid;
        logic ovr;
        logic tc;
    } stat_t;

    localparam int CTRL_BITS = $bits(ctrl_t);
    localparam int ST_TC     = 0;
    localparam int ST_OVR    = 1;
    localparam int ST_VLD    = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RD   = 2'd1,
        PH_WR   = 2'd2,
        PH_ACK  = 2'd3
    } phase_e;

    // Events from the transfer engine to the register file.
    typedef struct packed {
        logic start;
        logic step;
        logic reload;
        logic stop;
        logic set_tc;
        logic set_ovr;
    } eng_evt_t;

    function automatic logic irq_of(input stat_t s, input ctrl_t c);
        return (s.tc & c.tc_ie) | (s.ovr & c.ovr_ie);
    endfunction

endpackage

// File: rtl/dbuf_dma_engine.sv
`timescale 1ns/1ps
module dbuf_dma_engine
    import dbuf_dma_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         pflow,
    input  logic         autoload,
    input  logic         rld_valid,
    input  logic         cnt_is_one,
    input  logic         dreq,
    input  logic         dreq_last,
    input  logic [W-1:0] cur_src,
    input  logic [W-1:0] cur_dst,
    output logic         mem_rd,
    output logic         mem_wr,
    output logic [W-1:0] mem_addr,
    output logic         dack,
    output eng_evt_t     evt
);

    phase_e ph_q;
    logic   last_q;
    logic   blk_end;
    logic   take;

    assign take = (ph_q == PH_IDLE) && en && dreq;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            last_q <= 1'b0;
        end else begin
            unique case (ph_q)
                PH_IDLE: if (take) begin
                    ph_q   <= PH_RD;
                    last_q <= dreq_last;
                end
                PH_RD:   ph_q <= PH_WR;
                PH_WR:   ph_q <= PH_ACK;
                PH_ACK:  ph_q <= PH_IDLE;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // Block end is judged in the write cycle from the count before the step.
    always_comb begin
        blk_end     = (ph_q == PH_WR) && (pflow ? last_q : cnt_is_one);
        evt.start   = take;
        evt.step    = (ph_q == PH_WR);
        evt.reload  = blk_end && autoload && rld_valid;
        evt.stop    = blk_end && !(autoload && rld_valid);
        evt.set_tc  = blk_end && (!autoload || !pflow);
        evt.set_ovr = blk_end && !(autoload && rld_valid);
    end

    assign mem_rd   = (ph_q == PH_RD);
    assign mem_wr   = (ph_q == PH_WR);
    assign mem_addr = (ph_q == PH_RD) ? cur_src : cur_dst;
    assign dack     = (ph_q == PH_ACK);

endmodule

// File: rtl/dbuf_dma_regs.sv
`timescale 1ns/1ps
module dbuf_dma_regs
    import dbuf_dma_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sw_we,
    input  logic [2:0]   sw_addr,
    input  logic [W-1:0] sw_wdata,
    output logic [W-1:0] sw_rdata,
    input  eng_evt_t     evt,
    output ctrl_t        ctrl,
    output stat_t        stat,
    output logic [W-1:0] cur_src,
    output logic [W-1:0] cur_dst,
    output logic [W-1:0] cur_cnt,
    output logic [W-1:0] rld_cnt
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] rld_src;
    logic [W-1:0] rld_dst;
    logic         wr_ctrl, wr_stat, wr_csrc, wr_cdst, wr_ccnt;
    logic         wr_rsrc, wr_rdst, wr_rcnt;

    always_comb begin
        wr_ctrl = sw_we && (sw_addr == RA_CTRL);
        wr_stat = sw_we && (sw_addr == RA_STAT);
        wr_csrc = sw_we && (sw_addr == RA_CSRC);
        wr_cdst = sw_we && (sw_addr == RA_CDST);
        wr_ccnt = sw_we && (sw_addr == RA_CCNT);
        wr_rsrc = sw_we && (sw_addr == RA_RSRC);
        wr_rdst = sw_we && (sw_addr == RA_RDST);
        wr_rcnt = sw_we && (sw_addr == RA_RCNT);
    end

    // Control: a stop from the engine overrides a same-cycle software write.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            if (wr_ctrl)  ctrl    <= ctrl_t'(sw_wdata[CTRL_BITS-1:0]);
            if (evt.stop) ctrl.en <= 1'b0;
        end
    end

    // Status: engine sets win over write-one-to-clear; a reload-count write
    // wins over the engine consuming the shadow set.
    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            if (wr_stat && sw_wdata[ST_TC])  stat.tc    <= 1'b0;
            if (wr_stat && sw_wdata[ST_OVR]) stat.ovr   <= 1'b0;
            if (wr_stat && sw_wdata[ST_VLD]) stat.valid <= 1'b0;
            if (evt.set_tc)                  stat.tc    <= 1'b1;
            if (evt.set_ovr)                 stat.ovr   <= 1'b1;
            if (evt.reload)                  stat.valid <= 1'b0;
            if (wr_rcnt)                     stat.valid <= 1'b1;
            if (evt.start)                   stat.active <= 1'b1;
            if (evt.stop)                    stat.active <= 1'b0;
        end
    end

    // Current block parameters.
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_src <= '0;
            cur_dst <= '0;
            cur_cnt <= '0;
        end else if (evt.reload) begin
            cur_src <= rld_src;
            cur_dst <= rld_dst;
            cur_cnt <= rld_cnt;
        end else if (evt.step) begin
            cur_src <= cur_src + ONE;
            cur_dst <= cur_dst + ONE;
            cur_cnt <= cur_cnt - ONE;
        end else if (!stat.active) begin
            if (wr_csrc) cur_src <= sw_wdata;
            if (wr_cdst) cur_dst <= sw_wdata;
            if (wr_ccnt) cur_cnt <= sw_wdata;
        end
    end

    // Shadow reload set, writable at any time.
    always_ff @(posedge clk) begin
        if (rst) begin
            rld_src <= '0;
            rld_dst <= '0;
            rld_cnt <= '0;
        end else begin
            if (wr_rsrc) rld_src <= sw_wdata;
            if (wr_rdst) rld_dst <= sw_wdata;
            if (wr_rcnt) rld_cnt <= sw_wdata;
        end
    end

    always_comb begin
        unique case (sw_addr)
            RA_CTRL: sw_rdata = W'(ctrl);
            RA_STAT: sw_rdata = W'(stat);
            RA_CSRC: sw_rdata = cur_src;
            RA_CDST: sw_rdata = cur_dst;
            RA_CCNT: sw_rdata = cur_cnt;
            RA_RSRC: sw_rdata = rld_src;
            RA_RDST: sw_rdata = rld_dst;
            default: sw_rdata = rld_cnt;
        endcase
    end

endmodule

// File: rtl/dbuf_dma_chan.sv
`timescale 1ns/1ps
module dbuf_dma_chan
    import dbuf_dma_pkg::*;
#(
    parameter int W  = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sw_we,
    input  logic [2:0]    sw_addr,
    input  logic [W-1:0]  sw_wdata,
    output logic [W-1:0]  sw_rdata,
    input  logic          dreq,
    input  logic          dreq_last,
    output logic          dack,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [W-1:0]  mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          irq
);

    ctrl_t        ctrl;
    stat_t        stat;
    eng_evt_t     evt;
    logic [W-1:0] cur_src;
    logic [W-1:0] cur_dst;
    logic [W-1:0] cur_cnt;
    logic [W-1:0] rld_cnt;

    dbuf_dma_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .sw_we    (sw_we),
        .sw_addr  (sw_addr),
        .sw_wdata (sw_wdata),
        .sw_rdata (sw_rdata),
        .evt      (evt),
        .ctrl     (ctrl),
        .stat     (stat),
        .cur_src  (cur_src),
        .cur_dst  (cur_dst),
        .cur_cnt  (cur_cnt),
        .rld_cnt  (rld_cnt)
    );

    dbuf_dma_engine #(.W(W)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .en         (ctrl.en),
        .pflow      (ctrl.pflow),
        .autoload   (ctrl.autoload),
        .rld_valid  (stat.valid),
        .cnt_is_one (cur_cnt == W'(1)),
        .dreq       (dreq),
        .dreq_last  (dreq_last),
        .cur_src    (cur_src),
        .cur_dst    (cur_dst),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_addr   (mem_addr),
        .dack       (dack),
        .evt        (evt)
    );

    // Read data arrives in the write cycle and is forwarded unregistered.
    assign mem_wdata = mem_rdata;
    assign irq       = irq_of(stat, ctrl);

endmodule

// File: rtl/dbuf_dma_chk.sv
`timescale 1ns/1ps
module dbuf_dma_chk
    import dbuf_dma_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         mem_rd,
    input logic         mem_wr,
    input logic         dack,
    input logic         sw_we,
    input logic [2:0]   sw_addr,
    input stat_t        stat,
    input logic         step,
    input logic         reload,
    input logic [W-1:0] cur_cnt,
    input logic [W-1:0] rld_cnt
);

    assert_rd_then_wr_R2: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> mem_wr);

    assert_wr_then_ack_R2: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> dack);

    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_ack_single_R11: assert property (@(posedge clk) disable iff (rst)
        dack |=> (!dack && !mem_rd));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !reload) |=> (cur_cnt == $past(cur_cnt) - W'(1)));

    assert_tc_at_write_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.tc) |-> $past(mem_wr));

    assert_rcnt_sets_valid_R6: assert property (@(posedge clk) disable iff (rst)
        (sw_we && sw_addr == RA_RCNT) |=> stat.valid);

    assert_reload_copy_R7: assert property (@(posedge clk) disable iff (rst)
        reload |=> ((cur_cnt == $past(rld_cnt)) && stat.active));

    assert_reload_consumes_R7: assert property (@(posedge clk) disable iff (rst)
        (reload && !(sw_we && sw_addr == RA_RCNT)) |=> !stat.valid);

    assert_ovr_halts_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.ovr) |-> !stat.active);

endmodule

bind dbuf_dma_chan dbuf_dma_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .dack    (dack),
    .sw_we   (sw_we),
    .sw_addr (sw_addr),
    .stat    (stat),
    .step    (evt.step),
    .reload  (evt.reload),
    .cur_cnt (cur_cnt),
    .rld_cnt (rld_cnt)
);

// File: tb/dbuf_dma_chan_tb.sv
`timescale 1ns/1ps
module dbuf_dma_chan_tb;

    localparam int W  = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sw_we = 1'b0;
    logic [2:0]    sw_addr = 3'd0;
    logic [W-1:0]  sw_wdata = '0;
    logic [W-1:0]  sw_rdata;
    logic          dreq = 1'b0;
    logic          dreq_last = 1'b0;
    logic          dack;
    logic          mem_rd, mem_wr;
    logic [W-1:0]  mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          irq;

    always #4 clk = ~clk;

    dbuf_dma_chan #(.W(W), .DW(DW)) u_dut (
        .clk(clk), .rst(rst), .sw_we(sw_we), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .dreq(dreq),
        .dreq_last(dreq_last), .dack(dack), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .irq(irq)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit saw_rd = 1'b0;
    int pend   = 0;
    bit plast_mode = 1'b0;

    function automatic logic [7:0] pat(input logic [7:0] a);
        return a * 8'd7 + 8'd3;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act_v, input longint exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act_v, exp_v);
        end
    endtask

    // Memory: registered read, one byte per address.
    logic [7:0] mem [256];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(i[7:0]);
        end else begin
            if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
            if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    // Peripheral: raises a request while bytes are pending, drops it on ack.
    always @(negedge clk) begin
        if (rst) begin
            dreq = 1'b0;
            dreq_last = 1'b0;
        end else if (dack) begin
            pend = pend - 1;
            dreq = 1'b0;
            dreq_last = 1'b0;
        end else if (pend > 0 && !dreq) begin
            dreq = 1'b1;
            dreq_last = plast_mode && (pend == 1);
        end else if (pend <= 0) begin
            dreq = 1'b0;
            dreq_last = 1'b0;
        end
    end

    // Behavioural reference model, advanced on each rising edge.
    int           m_ph;
    logic [W-1:0] m_src, m_dst, m_cnt, r_src, r_dst, r_cnt;
    bit           en, pf, au, tie, oie, tc, ovr, vld, act, mlast;
    bit           o_en, o_pf, o_au, o_vld, o_act, endb, we;
    int           wa;
    logic [W-1:0] wd, o_rs, o_rd, o_rc;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_src = '0; m_dst = '0; m_cnt = '0;
            r_src = '0; r_dst = '0; r_cnt = '0;
            en = 0; pf = 0; au = 0; tie = 0; oie = 0;
            tc = 0; ovr = 0; vld = 0; act = 0; mlast = 0;
        end else begin
            we = sw_we; wa = int'(sw_addr); wd = sw_wdata;
            o_en = en; o_pf = pf; o_au = au; o_vld = vld; o_act = act;
            o_rs = r_src; o_rd = r_dst; o_rc = r_cnt;
            if (we && wa == 0) begin
                en = wd[0]; pf = wd[1]; au = wd[2]; tie = wd[3]; oie = wd[4];
            end
            if (we && wa == 1) begin
                if (wd[0]) tc = 0;
                if (wd[1]) ovr = 0;
                if (wd[2]) vld = 0;
            end
            if (we && !o_act && wa == 2) m_src = wd;
            if (we && !o_act && wa == 3) m_dst = wd;
            if (we && !o_act && wa == 4) m_cnt = wd;
            if (we && wa == 5) r_src = wd;
            if (we && wa == 6) r_dst = wd;
            if (we && wa == 7) r_cnt = wd;
            case (m_ph)
                0: if (o_en && dreq) begin
                    m_ph = 1; act = 1; mlast = dreq_last;
                end
                1: m_ph = 2;
                2: begin
                    m_ph = 3;
                    endb = o_pf ? mlast : (m_cnt == 1);
                    m_src = m_src + 1; m_dst = m_dst + 1; m_cnt = m_cnt - 1;
                    if (endb) begin
                        if (!o_au) begin
                            tc = 1; ovr = 1; act = 0; en = 0;
                        end else begin
                            if (!o_pf) tc = 1;
                            if (o_vld) begin
                                m_src = o_rs; m_dst = o_rd; m_cnt = o_rc; vld = 0;
                            end else begin
                                ovr = 1; act = 0; en = 0;
                            end
                        end
                    end
                end
                default: m_ph = 0;
            endcase
            if (we && wa == 7) vld = 1;
        end
    end

    // Every-clock comparison of the port behaviour (R2, R10, R11).
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (mem_rd) saw_rd = 1'b1;
            chk(mem_rd == (m_ph == 1), "R2", "mem_rd", mem_rd, m_ph == 1);
            chk(mem_wr == (m_ph == 2), "R2", "mem_wr", mem_wr, m_ph == 2);
            chk(dack == (m_ph == 3), "R11", "dack", dack, m_ph == 3);
            chk(irq == ((tc && tie) || (ovr && oie)), "R10", "irq", irq, (tc && tie) || (ovr && oie));
            if (m_ph == 1) chk(mem_addr == m_src, "R2", "read address", mem_addr, m_src);
            if (m_ph == 2) begin
                chk(mem_addr == m_dst, "R2", "write address", mem_addr, m_dst);
                chk(mem_wdata == pat(m_src[7:0]), "R2", "write data", mem_wdata, pat(m_src[7:0]));
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        sw_addr = a[2:0]; sw_wdata = d[W-1:0]; sw_we = 1'b1;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic rd(input int a, input int e, input string rq, input string what);
        @(negedge clk);
        sw_addr = a[2:0];
        #1;
        chk(sw_rdata == e[W-1:0], rq, what, sw_rdata, e);
    endtask

    task automatic wait_stop();
        int n = 0;
        while (!act && n < 2000) begin @(negedge clk); n++; end
        while ((act || m_ph != 0) && n < 4000) begin @(negedge clk); n++; end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "all", "watchdog expired", 0, 1);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        for (int a = 0; a < 8; a++) rd(a, 0, "R1", "register after reset");
        chk(!irq && !dack && !mem_rd && !mem_wr, "R1", "outputs after reset",
            {irq, dack, mem_rd, mem_wr}, 0);

        // R9, R4, R3, R2: single block, non-auto, channel flow
        wr(2, 'h10); wr(3, 'h80); wr(4, 4);
        pend = 4;
        wr(0, 25);
        wait_stop();
        rd(1, 3, "R9", "status after non-auto end");
        rd(0, 24, "R9", "enable cleared");
        rd(2, 'h14, "R3", "source after 4 bytes");
        rd(3, 'h84, "R3", "destination after 4 bytes");
        rd(4, 0, "R4", "count reached zero");
        chk(irq == 1'b1, "R10", "irq with tc and ovr enabled", irq, 1);
        for (int i = 0; i < 4; i++)
            chk(mem['h80 + i] == pat(8'h10 + i[7:0]), "R2", "copied byte", mem['h80 + i], pat(8'h10 + i[7:0]));
        wr(1, 3);
        rd(1, 0, "R6", "status after write-one-to-clear");
        chk(irq == 1'b0, "R10", "irq after clear", irq, 0);

        // R6, R7, R8: double buffering with one reload then overrun
        wr(2, 'h20); wr(3, 'h90); wr(4, 2);
        wr(5, 'h30); wr(6, 'hA0);
        rd(1, 0, "R6", "valid not set by reload addresses");
        wr(7, 3);
        rd(1, 4, "R6", "valid set by reload count");
        pend = 5;
        wr(0, 13);
        for (int n = 0; n < 2000 && m_src != 'h30; n++) @(negedge clk);
        rd(1, 9, "R7", "active kept, valid consumed, tc set");
        rd(2, 'h30, "R7", "source reloaded");
        wait_stop();
        rd(1, 3, "R8", "overrun after missing reload");
        rd(0, 12, "R8", "enable cleared on overrun");
        rd(2, 'h33, "R7", "source after reloaded block");
        rd(4, 0, "R4", "count after reloaded block");
        for (int i = 0; i < 2; i++)
            chk(mem['h90 + i] == pat(8'h20 + i[7:0]), "R7", "first block byte", mem['h90 + i], pat(8'h20 + i[7:0]));
        for (int i = 0; i < 3; i++)
            chk(mem['hA0 + i] == pat(8'h30 + i[7:0]), "R7", "reloaded block byte", mem['hA0 + i], pat(8'h30 + i[7:0]));
        chk(irq == 1'b1, "R10", "irq from tc", irq, 1);
        wr(1, 1);
        rd(1, 2, "R6", "only tc cleared");
        chk(irq == 1'b0, "R10", "overrun without its enable", irq, 0);
        wr(1, 2);

        // R5: peripheral flow, double-buffer mode, no reload
        wr(2, 'h38); wr(3, 'hB0); wr(4, 10);
        plast_mode = 1'b1;
        pend = 3;
        wr(0, 23);
        wait_stop();
        plast_mode = 1'b0;
        rd(1, 2, "R5", "no tc under peripheral flow");
        rd(4, 7, "R5", "count after last request");
        rd(3, 'hB3, "R5", "destination after last request");
        rd(0, 22, "R8", "enable cleared");
        chk(irq == 1'b1, "R10", "irq from overrun", irq, 1);
        wr(1, 2);

        // R6: valid cleared by write-one-to-clear
        wr(7, 5);
        rd(1, 4, "R6", "valid set");
        wr(1, 4);
        rd(1, 0, "R6", "valid cleared");

        // R11: held request while disabled
        wr(0, 0);
        saw_rd = 1'b0;
        pend = 1;
        repeat (20) @(negedge clk);
        chk(!saw_rd, "R11", "memory access while disabled", saw_rd, 0);
        rd(1, 0, "R11", "status untouched while disabled");
        pend = 0;
        repeat (3) @(negedge clk);

        // R12: current-register writes ignored while active
        wr(2, 'h08); wr(3, 'hC0); wr(4, 6);
        pend = 6;
        wr(0, 1);
        for (int n = 0; n < 2000 && !act; n++) @(negedge clk);
        wr(4, 'h55);
        wr(2, 'h00);
        wait_stop();
        rd(4, 0, "R12", "count write ignored");
        rd(2, 'h0E, "R12", "source write ignored");
        rd(1, 3, "R9", "status after second non-auto block");
        wr(1, 3);

        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule